// File: doc/BRIEF.md
# Endianness Conversion Byte-Swap Unit

This unit carries out the byte-order conversion group of a small register-machine instruction set. It receives the value of the destination register, the instruction class (32-bit or 64-bit arithmetic), the single byte-order select bit of the opcode, and the immediate. In this group the immediate does not act as an operand. It only gives the width of the operation. The unit returns the converted value together with a flag that marks an encoding it cannot legally execute.

The host byte order is fixed at build time by a parameter. In the 32-bit class, the select bit names a target order, either little or big endian. Bytes are reversed only when that target order differs from the host order. In the 64-bit class, bytes are always reversed. The select bit is reserved there and has to be zero.

The unit returns its result through one register stage. Inputs sampled at a rising clock edge appear on the outputs right after that edge.

Top module: `bswap_unit`

## Requirements
- R1: While `rstN` is low, `resultOut` reads 0 and `illegalOut` reads 0.
- R2: The result and flag for the inputs sampled at a rising edge appear right after that edge and hold until the next edge.
- R3: In the 32-bit class (`isWide`=0) with `srcSel`=0, meaning a little-endian target, the low bytes are reversed only when `HOST_LITTLE_ENDIAN`=0.
- R4: In the 32-bit class with `srcSel`=1, meaning a big-endian target, the low bytes are reversed only when `HOST_LITTLE_ENDIAN`=1.
- R5: In the 64-bit class (`isWide`=1) with `srcSel`=0, the low bytes are reversed for either host order.
- R6: In the 64-bit class with `srcSel`=1, `illegalOut` is 1 and `resultOut` equals `dstIn` unchanged.
- R7: The only legal values of `widthImm` are 16, 32 and 64. The full 32-bit value is compared. Bits at and above the width are 0 in a legal result.
- R8: Any other `widthImm` value sets `illegalOut` to 1 and returns `dstIn` unchanged.
- R9: When no reversal takes place, the low width bits pass through in their original order. They are still cut to the width.
- R10: A reversal of width W places byte i of the input (bits 8i+7..8i) at byte W/8-1-i of the result, for i from 0 to W/8-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| dstIn | input | 64 | Destination register value |
| isWide | input | 1 | Class: 0 = 32-bit class, 1 = 64-bit class |
| srcSel | input | 1 | Byte-order select bit: 0 = little-endian target, 1 = big-endian target |
| widthImm | input | 32 | Immediate giving the operation width |
| resultOut | output | 64 | Converted value (registered) |
| illegalOut | output | 1 | Illegal encoding flag (registered) |

## Verification
Two checks can land in the same cycle: the reserved-bit check of the 64-bit class and the width decode with its reversal and truncation. An example is a 64-bit instruction with `srcSel`=1 and a legal width of 16. Here the illegal path has to win, so the full 64-bit input returns untruncated and unreversed. The sweep crosses every class, select bit and immediate, including legal widths, against two builds that differ only in host order. Each pair of result and flag is compared with a model in the bench that reverses bytes arithmetically.

// File: rtl/bswap_pkg.sv
package bswap_pkg;
  localparam int DATA_W = 64;
  localparam int BYTE_W = 8;
  localparam int MIN_W  = 16;
  localparam int NUM_W  = $clog2(DATA_W / MIN_W) + 1;

  typedef struct packed {
    logic             swapEn;
    logic             illegal;
    logic [NUM_W-1:0] widthSel;
  } bswap_ctrl_t;
endpackage

// File: rtl/bswap_ctrl.sv
module bswap_ctrl
  import bswap_pkg::*;
#(
  parameter bit HOST_LITTLE_ENDIAN = 1'b1
) (
  input  logic        isWide,
  input  logic        srcSel,
  input  logic [31:0] widthImm,
  output bswap_ctrl_t ctrl
);
  logic [NUM_W-1:0] hit;

  for (genvar k = 0; k < NUM_W; k++) begin : g_dec
    assign hit[k] = (widthImm == 32'(MIN_W << k));
  end

  always_comb begin
    ctrl.widthSel = hit;
    ctrl.illegal  = (hit == '0) || (isWide && srcSel);
    if (isWide) ctrl.swapEn = 1'b1;
    else        ctrl.swapEn = (srcSel == HOST_LITTLE_ENDIAN);
  end
endmodule

// File: rtl/bswap_datapath.sv
module bswap_datapath
  import bswap_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] dstIn,
  input  bswap_ctrl_t       ctrl,
  output logic [DATA_W-1:0] resultOut,
  output logic              illegalOut
);
  logic [DATA_W-1:0] laneSwap [NUM_W];
  logic [DATA_W-1:0] laneKeep [NUM_W];
  logic [DATA_W-1:0] nxtResult;

  for (genvar k = 0; k < NUM_W; k++) begin : g_lane
    localparam int W  = MIN_W << k;
    localparam int NB = W / BYTE_W;
    localparam logic [DATA_W-1:0] MASK = {DATA_W{1'b1}} >> (DATA_W - W);
    logic [DATA_W-1:0] rev;
    always_comb begin
      rev = '0;
      for (int b = 0; b < NB; b++)
        rev[b*BYTE_W +: BYTE_W] = dstIn[(NB-1-b)*BYTE_W +: BYTE_W];
    end
    assign laneSwap[k] = rev;
    assign laneKeep[k] = dstIn & MASK;
  end

  always_comb begin
    nxtResult = '0;
    for (int k = 0; k < NUM_W; k++)
      if (ctrl.widthSel[k])
        nxtResult = nxtResult | (ctrl.swapEn ? laneSwap[k] : laneKeep[k]);
    if (ctrl.illegal) nxtResult = dstIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultOut  <= '0;
      illegalOut <= 1'b0;
    end else begin
      resultOut  <= nxtResult;
      illegalOut <= ctrl.illegal;
    end
  end
endmodule

// File: rtl/bswap_unit.sv
module bswap_unit
  import bswap_pkg::*;
#(
  parameter bit HOST_LITTLE_ENDIAN = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [63:0] dstIn,
  input  logic        isWide,
  input  logic        srcSel,
  input  logic [31:0] widthImm,
  output logic [63:0] resultOut,
  output logic        illegalOut
);
  bswap_ctrl_t ctrl;

  bswap_ctrl #(.HOST_LITTLE_ENDIAN(HOST_LITTLE_ENDIAN)) u_ctrl (
    .isWide(isWide), .srcSel(srcSel), .widthImm(widthImm), .ctrl(ctrl)
  );

  bswap_datapath u_dp (
    .clk(clk), .rstN(rstN), .dstIn(dstIn), .ctrl(ctrl),
    .resultOut(resultOut), .illegalOut(illegalOut)
  );
endmodule

// File: rtl/bswap_unit_chk.sv
module bswap_unit_chk #(
  parameter bit HOST_LITTLE_ENDIAN = 1'b1
) (
  input logic        clk,
  input logic        rstN,
  input logic [63:0] dstIn,
  input logic        isWide,
  input logic        srcSel,
  input logic [31:0] widthImm,
  input logic [63:0] resultOut,
  input logic        illegalOut
);
  logic seen;
  logic legalImm;
  assign legalImm = (widthImm == 32'd16) || (widthImm == 32'd32) || (widthImm == 32'd64);

  always_ff @(posedge clk) seen <= rstN;

  // R6: reserved select bit in the 64-bit class
  assert_wide_rsvd_R6: assert property (@(posedge clk) disable iff (!rstN)
    (seen && $past(isWide && srcSel)) |-> (illegalOut && resultOut == $past(dstIn)));

  // R8: unknown width
  assert_bad_width_R8: assert property (@(posedge clk) disable iff (!rstN)
    (seen && !$past(legalImm)) |-> (illegalOut && resultOut == $past(dstIn)));

  // R7: upper bits cleared
  assert_clear_upper_R7: assert property (@(posedge clk) disable iff (!rstN)
    (seen && !illegalOut && $past(widthImm) == 32'd16) |-> (resultOut[63:16] == 48'h0));

  assert_clear_upper32_R7: assert property (@(posedge clk) disable iff (!rstN)
    (seen && !illegalOut && $past(widthImm) == 32'd32) |-> (resultOut[63:32] == 32'h0));

  // R5: 64-bit class always reverses
  assert_wide_swap_R5: assert property (@(posedge clk) disable iff (!rstN)
    (seen && $past(isWide && !srcSel && widthImm == 32'd16)) |->
      (resultOut[15:0] == {$past(dstIn[7:0]), $past(dstIn[15:8])}));

  // R3 / R4: reversal decision in the 32-bit class against host order
  assert_narrow_order_R4: assert property (@(posedge clk) disable iff (!rstN)
    (seen && $past(!isWide && widthImm == 32'd16)) |->
      (resultOut[15:0] == (($past(srcSel) == HOST_LITTLE_ENDIAN) ?
         {$past(dstIn[7:0]), $past(dstIn[15:8])} : $past(dstIn[15:0]))));
endmodule

bind bswap_unit bswap_unit_chk #(.HOST_LITTLE_ENDIAN(HOST_LITTLE_ENDIAN)) u_chk (
  .clk(clk), .rstN(rstN), .dstIn(dstIn), .isWide(isWide), .srcSel(srcSel),
  .widthImm(widthImm), .resultOut(resultOut), .illegalOut(illegalOut)
);

// File: tb/sim_bswap_unit.sv
`timescale 1ns/1ps
module sim_bswap_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] dstIn = 64'h1122334455667788;
  logic        isWide = 1'b0;
  logic        srcSel = 1'b0;
  logic [31:0] widthImm = 32'd16;
  logic [63:0] resLe, resBe;
  logic        illLe, illBe;
  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bswap_unit u0 (
    .clk(clk), .rstN(rstN), .dstIn(dstIn), .isWide(isWide), .srcSel(srcSel),
    .widthImm(widthImm), .resultOut(resLe), .illegalOut(illLe)
  );
  bswap_unit #(.HOST_LITTLE_ENDIAN(1'b0)) u1 (
    .clk(clk), .rstN(rstN), .dstIn(dstIn), .isWide(isWide), .srcSel(srcSel),
    .widthImm(widthImm), .resultOut(resBe), .illegalOut(illBe)
  );

  function automatic logic [64:0] model(bit host, bit wide, bit src,
                                        logic [31:0] imm, logic [63:0] d);
    bit legal, ill, swap;
    int nb;
    logic [63:0] r;
    legal = (imm == 32'd16) || (imm == 32'd32) || (imm == 32'd64);
    ill = !legal || (wide && src);
    if (ill) return {1'b1, d};
    swap = wide ? 1'b1 : (src == host);
    nb = int'(imm) / 8;
    r = '0;
    for (int i = 0; i < nb; i++)
      r[8*i +: 8] = swap ? d[8*(nb-1-i) +: 8] : d[8*i +: 8];
    return {1'b0, r};
  endfunction

  function automatic string tagOf(bit host, bit wide, bit src, logic [31:0] imm);
    bit legal = (imm == 32'd16) || (imm == 32'd32) || (imm == 32'd64);
    if (!legal) return "R8";
    if (wide && src) return "R6";
    if (wide) return "R5/R10/R7";
    if (src == host) return src ? "R4/R10/R7" : "R3/R10/R7";
    return src ? "R4/R9" : "R3/R9";
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp,
                       logic actI, logic expI);
    vectors++;
    if (act !== exp || actI !== expI) begin
      fails++;
      $display("FAIL %s: got result %h flag %b, expected result %h flag %b",
               tag, act, actI, exp, expI);
    end
  endtask

  task automatic checkBoth(logic [64:0] eL, logic [64:0] eB, string tL, string tB);
    check(tL, resLe, eL[63:0], illLe, eL[64]);
    check(tB, resBe, eB[63:0], illBe, eB[64]);
  endtask

  initial begin
    logic [31:0] imms [8];
    logic [63:0] seed;
    logic [63:0] d;
    logic [64:0] eL, eB, pL, pB;
    imms[0] = 32'd16; imms[1] = 32'd32; imms[2] = 32'd64; imms[3] = 32'd0;
    imms[4] = 32'd8;  imms[5] = 32'd24; imms[6] = 32'd128; imms[7] = 32'h0001_0010;
    seed = 64'h0123_4567_89ab_cdef;

    // R1: reset state with active inputs
    repeat (3) @(posedge clk);
    #1;
    check("R1", resLe, 64'h0, illLe, 1'b0);
    check("R1", resBe, 64'h0, illBe, 1'b0);
    @(negedge clk);
    rstN = 1'b1;

    // R2: latency and hold
    dstIn = 64'h0102030405060708; isWide = 1'b1; srcSel = 1'b0; widthImm = 32'd64;
    @(posedge clk); #1;
    pL = model(1'b1, 1'b1, 1'b0, 32'd64, 64'h0102030405060708);
    check("R2", resLe, pL[63:0], illLe, pL[64]);
    @(negedge clk);
    dstIn = 64'hdead_beef_0000_ffff; widthImm = 32'd7;
    #1;
    check("R2", resLe, pL[63:0], illLe, pL[64]);

    for (int w = 0; w < 2; w++)
      for (int s = 0; s < 2; s++)
        for (int m = 0; m < 8; m++)
          for (int p = 0; p < 12; p++) begin
            if (p == 0)      d = 64'h0102030405060708;
            else if (p == 1) d = '1;
            else if (p == 2) d = '0;
            else begin
              seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
              d = seed;
            end
            @(negedge clk);
            dstIn = d; isWide = w[0]; srcSel = s[0]; widthImm = imms[m];
            eL = model(1'b1, w[0], s[0], imms[m], d);
            eB = model(1'b0, w[0], s[0], imms[m], d);
            @(posedge clk); #1;
            checkBoth(eL, eB, tagOf(1'b1, w[0], s[0], imms[m]),
                      tagOf(1'b0, w[0], s[0], imms[m]));
          end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule